// File: doc/BRIEF.md
# NAND Operation Trigger and Control Register Unit

This unit is the host-facing register bank of a NAND flash controller. Software starts one flash operation at a time by writing a one-hot trigger into the operation register. The unit then sends a single-cycle start pulse with an encoded opcode to a flash-side sequencing engine. The engine answers with a single-cycle done pulse, and the unit sets a sticky completion flag that software clears by writing. While the interrupt mask bit is clear, that flag drives the interrupt line.

Besides the trigger logic, the unit holds the controller's static settings. These are chip enable, pages-per-block code, byte order and full-page interrupt selection in the configuration register; the RAM buffer index and the active chip select in the buffer register; and half the spare byte count in the spare register. A soft reset bit in the configuration register stays set for a fixed number of cycles and then clears itself. While it is set, the operation state is cleared and triggers are refused.

Top module: `nand_opr_unit`

## Requirements
- R1: A write to the operation register (reg_addr 0) with exactly one of bits 5:0 set starts an operation if the unit is idle and no soft reset is running. In the cycle after the write edge, eng_start is high for one cycle and eng_op gives the set bit's index (0 command, 1 address, 2 page in, 3 page out, 4 ID read, 5 status read). Operation register bit 14 reads 1 (busy) until completion.
- R2: eng_done while busy clears bit 14 and sets bit 15 (completion) at the same edge. eng_done while idle changes nothing.
- R3: Bit 15 stays set until an accepted operation-register write carries 0 in bit 15. A write with bit 15 at 1 leaves the flag unchanged.
- R4: irq is high exactly while the completion flag is 1 and configuration bit 4 (mask) is 0.
- R5: An operation-register write while busy is ignored entirely: no start, and the flag and busy bits are unchanged.
- R6: A write with zero, or with two or more, of bits 5:0 set starts nothing. Its bit 15 still applies to the flag.
- R7: Starting a page in, page out, ID read or status read operation clears the buffer index to 0 at the write edge. Command and address operations leave it unchanged.
- R8: Writing configuration (reg_addr 1) with bit 6 at 1 starts a soft reset. Bit 6 then reads 1 for RST_CYCLES cycles and clears itself. From the write edge on and during the reset, busy, flag and buffer index are 0, and operation writes are ignored.
- R9: Configuration bits map as follows: bit 7 to chip_en, bits 10:9 to ppb_sel (0=32, 1=64, 2=128, 3=256 pages per block), bit 5 to big_endian, bit 11 to full_page_irq, bit 4 to the mask. The register reads back with its other bits at 0.
- R10: The buffer register (reg_addr 2) holds the buffer index in bits 2:0 (buf_idx) and the chip select in bits 6:5 (chip_sel). Its other bits read 0.
- R11: The spare register (reg_addr 3) holds half the spare byte count in bits 7:0 (spare_half). Its upper bits read 0.
- R12: After rst_n, every register reads 0 except configuration, which reads 0x0010 (masked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 operation, 1 configuration, 2 buffer, 3 spare |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| eng_start | output | 1 | One-cycle start pulse to the flash engine |
| eng_op | output | 3 | Opcode of the started operation |
| eng_done | input | 1 | One-cycle completion pulse from the flash engine |
| irq | output | 1 | Completion interrupt |
| chip_en | output | 1 | Chip enable |
| chip_sel | output | 2 | Active chip select |
| buf_idx | output | 3 | RAM buffer index |
| big_endian | output | 1 | Byte order select |
| full_page_irq | output | 1 | Interrupt after full page select |
| ppb_sel | output | 2 | Pages-per-block code |
| spare_half | output | 8 | Spare byte count divided by two |

## Verification
Each of the six trigger bits is fired in turn from a non-zero buffer index. This shows both that the opcode is encoded correctly and that the index is cleared only for data operations. Writes are also tried in several other conditions: while busy with the flag set, with two trigger bits set, with no trigger bit, with bit 15 at 1 or 0, and during a soft reset. These separate an accepted trigger from an ignored write and a flag clear from a flag hold. A stray done pulse while idle and mask toggling with the flag held show that completion and interrupt follow only the busy state and the mask. A behavioural model tracks every output and the read data on every clock.

// File: rtl/nand_opr_pkg.sv
package nand_opr_pkg;
    localparam int unsigned DW      = 16;
    localparam int unsigned N_TRIG  = 6;
    localparam int unsigned FLAG_B  = 15;
    localparam int unsigned BUSY_B  = 14;
    localparam int unsigned MASK_B  = 4;
    localparam int unsigned ENDN_B  = 5;
    localparam int unsigned SRST_B  = 6;
    localparam int unsigned CE_B    = 7;
    localparam int unsigned PPB_LO  = 9;
    localparam int unsigned FPI_B   = 11;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned CS_LO   = 5;
    localparam int unsigned CS_W    = 2;
    localparam int unsigned SPARE_W = 8;

    typedef enum logic [1:0] {
        RA_OP    = 2'd0,
        RA_CFG   = 2'd1,
        RA_BUF   = 2'd2,
        RA_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        OP_CMD   = 3'd0,
        OP_ADDR  = 3'd1,
        OP_PGIN  = 3'd2,
        OP_PGOUT = 3'd3,
        OP_ID    = 3'd4,
        OP_STAT  = 3'd5
    } op_code_e;

    function automatic logic [2:0] count_set(input logic [N_TRIG-1:0] v);
        logic [2:0] n;
        n = '0;
        for (int i = 0; i < N_TRIG; i++) n = n + {2'b0, v[i]};
        return n;
    endfunction
endpackage

// File: rtl/nand_opr_trigger.sv
module nand_opr_trigger
    import nand_opr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_wr,
    input  logic [DW-1:0] wdata,
    input  logic          rst_hold,
    input  logic          eng_done,
    output logic          busy,
    output logic          flag,
    output logic          start,
    output logic [2:0]    op,
    output logic          clr_idx
);
    typedef struct packed {
        logic       busy;
        logic       flag;
        logic       start;
        logic [2:0] op;
    } trig_s;

    trig_s      st_d, st_q;
    logic [2:0] hit_idx;
    logic [2:0] n_set;
    logic       accept;
    logic       launch;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (wdata[i]) hit_idx = 3'(i);
        end
        n_set   = count_set(wdata[N_TRIG-1:0]);
        accept  = op_wr && !st_q.busy && !rst_hold;
        launch  = accept && (n_set == 3'd1);
        clr_idx = launch && (hit_idx >= OP_PGIN);

        st_d       = st_q;
        st_d.start = 1'b0;
        if (rst_hold) begin
            st_d.busy = 1'b0;
            st_d.flag = 1'b0;
        end else begin
            if (st_q.busy && eng_done) begin
                st_d.busy = 1'b0;
                st_d.flag = 1'b1;
            end
            if (accept && !wdata[FLAG_B]) st_d.flag = 1'b0;
            if (launch) begin
                st_d.busy  = 1'b1;
                st_d.start = 1'b1;
                st_d.op    = hit_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy  = st_q.busy;
    assign flag  = st_q.flag;
    assign start = st_q.start;
    assign op    = st_q.op;
endmodule

// File: rtl/nand_opr_cfg.sv
module nand_opr_cfg
    import nand_opr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [DW-1:0] wdata,
    output logic          rst_hold,
    output logic          rst_busy,
    output logic          mask,
    output logic          big_endian,
    output logic          chip_en,
    output logic [1:0]    ppb_sel,
    output logic          full_page_irq,
    output logic [DW-1:0] cfg_rd
);
    localparam int unsigned CNT_W = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RST_CYCLES - 1);

    typedef struct packed {
        logic             mask;
        logic             endn;
        logic             srst;
        logic             ce;
        logic [1:0]       ppb;
        logic             fpi;
        logic [CNT_W-1:0] cnt;
    } cfg_s;

    cfg_s st_d, st_q;
    logic kick;

    always_comb begin
        kick = cfg_wr && wdata[SRST_B] && !st_q.srst;
        st_d = st_q;
        if (st_q.srst) begin
            if (st_q.cnt == '0) st_d.srst = 1'b0;
            else                st_d.cnt  = st_q.cnt - 1'b1;
        end
        if (cfg_wr) begin
            st_d.mask = wdata[MASK_B];
            st_d.endn = wdata[ENDN_B];
            st_d.ce   = wdata[CE_B];
            st_d.ppb  = wdata[PPB_LO +: 2];
            st_d.fpi  = wdata[FPI_B];
        end
        if (kick) begin
            st_d.srst = 1'b1;
            st_d.cnt  = CNT_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rd             = '0;
        cfg_rd[MASK_B]     = st_q.mask;
        cfg_rd[ENDN_B]     = st_q.endn;
        cfg_rd[SRST_B]     = st_q.srst;
        cfg_rd[CE_B]       = st_q.ce;
        cfg_rd[PPB_LO +: 2] = st_q.ppb;
        cfg_rd[FPI_B]      = st_q.fpi;
    end

    assign rst_hold      = kick || st_q.srst;
    assign rst_busy      = st_q.srst;
    assign mask          = st_q.mask;
    assign big_endian    = st_q.endn;
    assign chip_en       = st_q.ce;
    assign ppb_sel       = st_q.ppb;
    assign full_page_irq = st_q.fpi;
endmodule

// File: rtl/nand_opr_bufsel.sv
module nand_opr_bufsel
    import nand_opr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               buf_wr,
    input  logic               spare_wr,
    input  logic [DW-1:0]      wdata,
    input  logic               clr_idx,
    input  logic               rst_hold,
    output logic [IDX_W-1:0]   buf_idx,
    output logic [CS_W-1:0]    chip_sel,
    output logic [SPARE_W-1:0] spare_half,
    output logic [DW-1:0]      buf_rd,
    output logic [DW-1:0]      spare_rd
);
    typedef struct packed {
        logic [IDX_W-1:0]   idx;
        logic [CS_W-1:0]    cs;
        logic [SPARE_W-1:0] spare;
    } buf_s;

    buf_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (buf_wr) begin
            st_d.idx = wdata[IDX_W-1:0];
            st_d.cs  = wdata[CS_LO +: CS_W];
        end
        if (spare_wr) st_d.spare = wdata[SPARE_W-1:0];
        if (clr_idx || rst_hold) st_d.idx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        buf_rd                  = '0;
        buf_rd[IDX_W-1:0]       = st_q.idx;
        buf_rd[CS_LO +: CS_W]   = st_q.cs;
        spare_rd                = '0;
        spare_rd[SPARE_W-1:0]   = st_q.spare;
    end

    assign buf_idx    = st_q.idx;
    assign chip_sel   = st_q.cs;
    assign spare_half = st_q.spare;
endmodule

// File: rtl/nand_opr_unit.sv
module nand_opr_unit
    import nand_opr_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        eng_start,
    output logic [2:0]  eng_op,
    input  logic        eng_done,
    output logic        irq,
    output logic        chip_en,
    output logic [1:0]  chip_sel,
    output logic [2:0]  buf_idx,
    output logic        big_endian,
    output logic        full_page_irq,
    output logic [1:0]  ppb_sel,
    output logic [7:0]  spare_half
);
    logic          op_wr, cfg_wr, buf_wr, spare_wr;
    logic          busy, flag, mask, rst_hold, rst_busy, clr_idx;
    logic [DW-1:0] cfg_rd, buf_rd, spare_rd, op_rd;

    assign op_wr    = reg_we && (reg_addr == RA_OP);
    assign cfg_wr   = reg_we && (reg_addr == RA_CFG);
    assign buf_wr   = reg_we && (reg_addr == RA_BUF);
    assign spare_wr = reg_we && (reg_addr == RA_SPARE);

    nand_opr_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .wdata(reg_wdata),
        .rst_hold(rst_hold), .eng_done(eng_done), .busy(busy), .flag(flag),
        .start(eng_start), .op(eng_op), .clr_idx(clr_idx)
    );

    nand_opr_cfg #(.RST_CYCLES(RST_CYCLES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .wdata(reg_wdata),
        .rst_hold(rst_hold), .rst_busy(rst_busy), .mask(mask),
        .big_endian(big_endian), .chip_en(chip_en), .ppb_sel(ppb_sel),
        .full_page_irq(full_page_irq), .cfg_rd(cfg_rd)
    );

    nand_opr_bufsel u_buf (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .spare_wr(spare_wr),
        .wdata(reg_wdata), .clr_idx(clr_idx), .rst_hold(rst_hold),
        .buf_idx(buf_idx), .chip_sel(chip_sel), .spare_half(spare_half),
        .buf_rd(buf_rd), .spare_rd(spare_rd)
    );

    always_comb begin
        op_rd         = '0;
        op_rd[FLAG_B] = flag;
        op_rd[BUSY_B] = busy;
        case (reg_addr)
            RA_OP:   reg_rdata = op_rd;
            RA_CFG:  reg_rdata = cfg_rd;
            RA_BUF:  reg_rdata = buf_rd;
            default: reg_rdata = spare_rd;
        endcase
    end

    assign irq = flag && !mask;
endmodule

// File: rtl/nand_opr_chk.sv
module nand_opr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       flag,
    input logic       mask,
    input logic       rst_busy,
    input logic       op_wr,
    input logic       eng_start,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       irq,
    input logic [2:0] buf_idx
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
    a_r1_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy);
    a_r1_opcode_range: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (eng_op <= 3'd5));
    a_r2_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && eng_done && !rst_busy) |=> (!busy && (flag || rst_busy)));
    a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq);
    a_r4_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !mask) |-> irq);
    a_r5_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_wr && !eng_done) |=> (busy && !eng_start));
    a_r7_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op >= 3'd2) |-> (buf_idx == 3'd0));
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rst_busy |-> (!busy && !flag && buf_idx == 3'd0 && !eng_start));
endmodule

bind nand_opr_unit nand_opr_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .flag(flag), .mask(mask),
    .rst_busy(rst_busy), .op_wr(op_wr), .eng_start(eng_start),
    .eng_op(eng_op), .eng_done(eng_done), .irq(irq), .buf_idx(buf_idx)
);

// File: tb/nand_opr_unit_tb.sv
`timescale 1ns/1ps
module nand_opr_unit_tb_top;
    localparam int RSTC = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        eng_start;
    logic [2:0]  eng_op;
    logic        eng_done = 1'b0;
    logic        irq, chip_en, big_endian, full_page_irq;
    logic [1:0]  chip_sel, ppb_sel;
    logic [2:0]  buf_idx;
    logic [7:0]  spare_half;

    int checks = 0, fails = 0;
    int eng_lat = 3;
    int e_cnt = 0;
    bit stray = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    nand_opr_unit #(.RST_CYCLES(RSTC)) dut_i (.*);

    // behavioural reference model
    bit m_busy, m_flag, m_start, m_mask, m_be, m_ce, m_fp, m_rst;
    int m_op, m_ppb, m_rcnt, m_idx, m_cs, m_spare;

    task automatic m_reset();
        m_busy = 0; m_flag = 0; m_start = 0; m_mask = 1; m_be = 0; m_ce = 0;
        m_fp = 0; m_rst = 0; m_op = 0; m_ppb = 0; m_rcnt = 0; m_idx = 0;
        m_cs = 0; m_spare = 0;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            bit o_busy, o_rst, kick;
            int n, hit;
            o_busy = m_busy; o_rst = m_rst; kick = 0;
            m_start = 0;
            if (o_rst) begin
                if (m_rcnt == 0) m_rst = 0; else m_rcnt--;
            end else if (o_busy && eng_done) begin
                m_busy = 0; m_flag = 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: if (!o_busy && !o_rst) begin
                        n = 0; hit = 0;
                        for (int i = 0; i < 6; i++)
                            if (reg_wdata[i]) begin n++; hit = i; end
                        if (!reg_wdata[15]) m_flag = 0;
                        if (n == 1) begin
                            m_busy = 1; m_start = 1; m_op = hit;
                            if (hit >= 2) m_idx = 0;
                        end
                    end
                    2'd1: begin
                        m_mask = reg_wdata[4]; m_be = reg_wdata[5];
                        m_ce = reg_wdata[7]; m_ppb = reg_wdata[10:9];
                        m_fp = reg_wdata[11];
                        if (reg_wdata[6] && !o_rst) begin
                            kick = 1; m_rst = 1; m_rcnt = RSTC - 1;
                        end
                    end
                    2'd2: begin m_idx = reg_wdata[2:0]; m_cs = reg_wdata[6:5]; end
                    default: m_spare = reg_wdata[7:0];
                endcase
            end
            if (kick || o_rst) begin m_busy = 0; m_flag = 0; m_idx = 0; end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int m_rdata(input int a);
        case (a)
            0: return (int'(m_flag) << 15) | (int'(m_busy) << 14);
            1: return (int'(m_fp) << 11) | (m_ppb << 9) | (int'(m_ce) << 7) |
                      (int'(m_rst) << 6) | (int'(m_be) << 5) | (int'(m_mask) << 4);
            2: return (m_cs << 5) | m_idx;
            default: return m_spare;
        endcase
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n) begin
        chk(irq == (m_flag && !m_mask), "R4 irq", irq, m_flag && !m_mask);
        chk(eng_start == m_start, "R1 eng_start", eng_start, m_start);
        if (m_start) chk(eng_op == m_op, "R1 eng_op", eng_op, m_op);
        chk({full_page_irq, ppb_sel, chip_en, big_endian} ==
            {m_fp, 2'(m_ppb), m_ce, m_be}, "R9 cfg outputs",
            {full_page_irq, ppb_sel, chip_en, big_endian},
            {m_fp, 2'(m_ppb), m_ce, m_be});
        chk(buf_idx == m_idx && chip_sel == m_cs && spare_half == m_spare,
            "R10 R11 buffer outputs", {spare_half, chip_sel, buf_idx},
            (m_spare << 5) | (m_cs << 3) | m_idx);
        chk(reg_rdata == m_rdata(reg_addr), "R3 readback", reg_rdata, m_rdata(reg_addr));
    end

    // flash engine model
    always @(negedge clk) begin
        done_flag = 0;
        if (e_cnt != 0) begin
            e_cnt--;
            if (e_cnt == 0) done_flag = 1;
        end
        if (eng_start) e_cnt = eng_lat;
        eng_done <= done_flag || stray;
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 2'(a); reg_wdata = 16'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        reg_addr = 2'(a);
        #1;
        chk(reg_rdata == 16'(exp), tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, 16'h0000, "R12 op reset");
        rd(1, 16'h0010, "R12 cfg reset");
        rd(2, 16'h0000, "R12 buf reset");
        rd(3, 16'h0000, "R12 spare reset");

        wr(1, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            wr(2, 16'h0045);
            wr(0, 1 << i);
            rd(0, 16'h4000, "R1 busy");
            idle(6);
            rd(0, 16'h8000, "R2 completion flag");
            chk(irq == 1'b1, "R4 irq unmasked", irq, 1);
            rd(2, (i >= 2) ? 16'h0040 : 16'h0045, "R7 buffer index");
            wr(0, 16'h8000);
            rd(0, 16'h8000, "R3 flag held");
            wr(0, 16'h0000);
            rd(0, 16'h0000, "R3 flag cleared");
        end

        stray = 1; idle(1); stray = 0; idle(2);
        rd(0, 16'h0000, "R2 stray done ignored");

        eng_lat = 20;
        wr(0, 16'h0001); idle(25);
        wr(0, 16'h8002);
        wr(0, 16'h0000);
        wr(0, 16'h0010);
        rd(0, 16'hC000, "R5 write while busy");
        idle(25);
        rd(0, 16'h8000, "R5 flag after done");

        wr(0, 16'h8003);
        idle(3);
        rd(0, 16'h8000, "R6 multi trigger");
        wr(0, 16'h0030);
        rd(0, 16'h0000, "R6 multi trigger clears flag");

        wr(0, 16'h0001); idle(25);
        wr(1, 16'h0010);
        chk(irq == 1'b0, "R4 irq masked", irq, 0);
        wr(1, 16'h0000);
        chk(irq == 1'b1, "R4 irq unmasked again", irq, 1);

        wr(2, 16'h0003);
        wr(0, 16'h0008);
        wr(1, 16'h0040);
        rd(1, 16'h0040, "R8 soft reset active");
        rd(0, 16'h0000, "R8 op cleared");
        wr(0, 16'h0001);
        wr(2, 16'h0007);
        rd(2, 16'h0000, "R8 index held");
        idle(RSTC + 2);
        rd(1, 16'h0000, "R8 soft reset done");
        rd(0, 16'h0000, "R8 write ignored");

        wr(1, 16'h0EA0);
        rd(1, 16'h0EA0, "R9 cfg readback");
        chk(chip_en && big_endian && full_page_irq && ppb_sel == 2'd3,
            "R9 cfg fields", {full_page_irq, ppb_sel, chip_en, big_endian}, 5'h1F);
        wr(1, 16'hF10F);
        rd(1, 16'h0000, "R9 reserved bits");

        wr(2, 16'hFFFF);
        rd(2, 16'h0067, "R10 buffer register");
        wr(3, 16'h1234);
        rd(3, 16'h0034, "R11 spare register");
        chk(spare_half == 8'h34, "R11 spare output", spare_half, 8'h34);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule